// File: doc/BRIEF.md
# Mixed-Sign 17x17 Multiplier

This block forms a 32-bit product from two 16-bit operands or from one 16-bit operand and a 5-bit literal. Every product comes out of a single signed 17-bit by 17-bit array. A 3-bit mode input picks how each operand is widened into bit 16. A signed operand is sign-extended. An unsigned operand, or the literal, gets a zero there. With this one array the block covers signed, unsigned and mixed-sign products, literal products and an 8-bit by 8-bit byte product.

Operands are captured on an input strobe. One clock later the product appears on a register, and a result-valid flag echoes the strobe. When no strobe arrives, the product register holds its previous value. The block is meant to sit in an execution stage: the surrounding datapath supplies the operands and consumes the product. This block does no register-file access, no decoding and no flag updates.

Top module: `mixedMul17`

## Requirements
- R1: While `rstN` is low, `product` is 0 and `outValid` is 0.
- R2: `outValid` is 1 in the cycle after a clock edge that saw `inValid` high, and 0 in the cycle after an edge that saw `inValid` low.
- R3: On an edge where `inValid` is low, `product` keeps its value, whatever the operand, literal and mode inputs are.
- R4: Mode 0 (3'b000): `product` = signed `opA` times signed `opB`, as the low 32 bits of the two's-complement result.
- R5: Mode 1 (3'b001): `product` = unsigned `opA` times unsigned `opB`.
- R6: Mode 2 (3'b010): `product` = unsigned `opA` times signed `opB`, two's complement.
- R7: Mode 3 (3'b011): `product` = signed `opA` times unsigned `opB`, two's complement.
- R8: Mode 4 (3'b100): `product` = signed `opA` times the unsigned literal `lit` (0 to 31). `opB` has no effect.
- R9: Mode 5 (3'b101): `product` = unsigned `opA` times the unsigned literal `lit`. `opB` has no effect.
- R10: Mode 6 (3'b110): `product[15:0]` = `opA[7:0]` times `opB[7:0]`, both unsigned, and `product[31:16]` = 0. `opA[15:8]`, `opB[15:8]` and `lit` have no effect.
- R11: Mode 7 (3'b111) behaves exactly like mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe; captures a new product |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand (unused in literal modes) |
| lit | input | 5 | Unsigned literal for modes 4 and 5 |
| mode | input | 3 | Operand extension mode, encodings per R4 to R11 |
| product | output | 32 | Registered product |
| outValid | output | 1 | Result-valid, the strobe delayed one cycle |

## Verification
Two things can happen in the same cycle: a new strobe is captured while the previous result is still on the outputs, and the mode changes from one strobe to the next. The bench holds `inValid` high across long runs so that every cycle loads a fresh product. Within those runs the mode, operands and literal change on every strobe. Each result is judged against an arithmetic model one cycle after its strobe. Cycles with the strobe low are also inserted, with the inputs scrambled, to confirm that the held product survives and that `outValid` drops.

// File: rtl/mulPkg.sv
package mulPkg;
  localparam int DATA_W = 16;
  localparam int LIT_W  = 5;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SS  = 3'd0,
    MODE_UU  = 3'd1,
    MODE_US  = 3'd2,
    MODE_SU  = 3'd3,
    MODE_SL  = 3'd4,
    MODE_UL  = 3'd5,
    MODE_BB  = 3'd6,
    MODE_RSV = 3'd7
  } mode_e;

  typedef struct packed {
    logic load;
    logic aSigned;
    logic bSigned;
    logic useLit;
    logic byteMode;
  } mulStrobe_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
#(
  parameter int MODE_BITS = MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [MODE_BITS-1:0] mode,
  output mulStrobe_t           strobe,
  output logic                 outValid
);
  mode_e modeSel;

  always_comb begin
    modeSel         = mode_e'(mode);
    strobe          = '0;
    strobe.load     = inValid;
    unique case (modeSel)
      MODE_SS: begin strobe.aSigned = 1'b1; strobe.bSigned = 1'b1; end
      MODE_US: strobe.bSigned = 1'b1;
      MODE_SU: strobe.aSigned = 1'b1;
      MODE_SL: begin strobe.aSigned = 1'b1; strobe.useLit = 1'b1; end
      MODE_UL: strobe.useLit = 1'b1;
      MODE_BB: strobe.byteMode = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int OP_W   = DATA_W,
  parameter int L_W    = LIT_W,
  parameter int B_W    = BYTE_W,
  localparam int CORE_W = OP_W + 1,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strobe,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [L_W-1:0]    lit,
  output logic [PROD_W-1:0] product
);
  logic [OP_W-1:0]          aSel, bSel, litWide;
  logic signed [CORE_W-1:0] aExt, bExt;
  logic signed [PROD_W-1:0] coreProd;

  assign litWide = {{(OP_W-L_W){1'b0}}, lit};

  always_comb begin
    if (strobe.byteMode) begin
      aSel = {{(OP_W-B_W){1'b0}}, opA[B_W-1:0]};
      bSel = {{(OP_W-B_W){1'b0}}, opB[B_W-1:0]};
    end else begin
      aSel = opA;
      bSel = strobe.useLit ? litWide : opB;
    end
    aExt = {strobe.aSigned & aSel[OP_W-1], aSel};
    bExt = {strobe.bSigned & bSel[OP_W-1], bSel};
  end

  assign coreProd = $signed(PROD_W'(aExt)) * $signed(PROD_W'(bExt));

  always_ff @(posedge clk) begin
    if (!rstN)            product <= '0;
    else if (strobe.load) product <= coreProd;
  end
endmodule

// File: rtl/mixedMul17.sv
module mixedMul17
  import mulPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  logic [LIT_W-1:0]     lit,
  input  logic [MODE_W-1:0]    mode,
  output logic [2*DATA_W-1:0]  product,
  output logic                 outValid
);
  mulStrobe_t strobe;

  mulCtrl #(.MODE_BITS(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .strobe(strobe), .outValid(outValid)
  );

  mulDatapath #(.OP_W(DATA_W), .L_W(LIT_W), .B_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .lit(lit), .product(product)
  );
endmodule

// File: rtl/mulChecker.sv
module mulChecker
  import mulPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [LIT_W-1:0]    lit,
  input logic [MODE_W-1:0]   mode,
  input logic [2*DATA_W-1:0] product,
  input logic                outValid
);
  localparam int PW = 2 * DATA_W;

  always_comb begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (product == '0 && outValid == 1'b0 || $time == 0) else $error("reset"); // R1
    end
  end

  AST_VALID_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(product)); // R3
  AST_SS_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_SS) |=>
      product == PW'($signed(PW'($signed($past(opA)))) * $signed(PW'($signed($past(opB)))))); // R4
  AST_UU_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_UU) |=> product == PW'($past(opA)) * PW'($past(opB))); // R5
  AST_UL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_UL) |=> product == PW'($past(opA)) * PW'($past(lit))); // R9
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_BB) |=> product[PW-1:DATA_W] == '0); // R10
endmodule

bind mixedMul17 mulChecker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .lit(lit), .mode(mode), .product(product), .outValid(outValid)
);

// File: tb/tb_mixedMul17.sv
module tb_mixedMul17;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] opA, opB;
  logic [4:0]  lit;
  logic [2:0]  mode;
  logic [31:0] product;
  logic        outValid;

  int checks = 0;
  int errors = 0;

  logic [15:0] corner [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001,
                               16'hFFFF, 16'h00FF, 16'h0100, 16'h1234, 16'hAAAA, 16'h5555};

  always #(CLK_PERIOD/2) clk = ~clk;

  mixedMul17 dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .lit(lit), .mode(mode), .product(product), .outValid(outValid)
  );

  function automatic logic [31:0] model(input logic [2:0] m, input logic [15:0] a,
                                        input logic [15:0] b, input logic [4:0] l);
    longint x, y;
    case (m)
      3'd0: begin x = longint'($signed(a)); y = longint'($signed(b)); end
      3'd2: begin x = longint'(a);          y = longint'($signed(b)); end
      3'd3: begin x = longint'($signed(a)); y = longint'(b);          end
      3'd4: begin x = longint'($signed(a)); y = longint'(l);          end
      3'd5: begin x = longint'(a);          y = longint'(l);          end
      3'd6: begin x = longint'(a[7:0]);     y = longint'(b[7:0]);     end
      default: begin x = longint'(a);       y = longint'(b);          end
    endcase
    return 32'(x * y);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] m);
    case (m)
      3'd0: return "R4"; 3'd1: return "R5"; 3'd2: return "R6"; 3'd3: return "R7";
      3'd4: return "R8"; 3'd5: return "R9"; 3'd6: return "R10"; default: return "R11";
    endcase
  endfunction

  // Drive one strobe at a negedge; judge its result at the following negedge.
  task automatic strobeOne(input logic [2:0] m, input logic [15:0] a,
                           input logic [15:0] b, input logic [4:0] l);
    logic [31:0] exp;
    exp = model(m, a, b, l);
    inValid = 1'b1; mode = m; opA = a; opB = b; lit = l;
    @(posedge clk); @(negedge clk);
    check(reqOf(m), product, exp);
    check("R2", {31'b0, outValid}, 32'd1);
  endtask

  task automatic idleOne();
    logic [31:0] held;
    held = product;
    inValid = 1'b0; mode = 3'($urandom); opA = 16'($urandom); opB = 16'($urandom); lit = 5'($urandom);
    @(posedge clk); @(negedge clk);
    check("R3", product, held);
    check("R2", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b1; opA = 16'hFFFF; opB = 16'hFFFF; lit = 5'h1F; mode = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", product, 32'd0);
    check("R1", {31'b0, outValid}, 32'd0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Register-operand modes over all corner pairs, back to back (R4 R5 R6 R7 R11)
    for (int m = 0; m < 8; m++) begin
      if (m == 4 || m == 5 || m == 6) continue;
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          strobeOne(3'(m), corner[i], corner[j], 5'(i + j));
      idleOne();
    end

    // Literal modes: every literal, every corner, opB scrambled (R8 R9)
    for (int m = 4; m < 6; m++)
      for (int l = 0; l < 32; l++)
        for (int i = 0; i < 12; i++)
          strobeOne(3'(m), corner[i], 16'($urandom), 5'(l));

    // Byte mode exhaustive, upper operand bits and literal scrambled (R10)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++)
        strobeOne(3'd6, {8'($urandom), 8'(a)}, {8'($urandom), 8'(b)}, 5'($urandom));
      if (a % 64 == 0) idleOne();
    end

    // Mode changes on every strobe, with idle gaps (R2 R3)
    for (int k = 0; k < 400; k++) begin
      strobeOne(3'($urandom), 16'($urandom), 16'($urandom), 5'($urandom));
      if (k % 7 == 0) idleOne();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule